// File: doc/BRIEF.md
# Display Command Word Parser

This block is the slave-side protocol layer of a display controller's two-wire serial port. A bit-level engine handles line sampling and framing and hands this block whole received bytes, together with start and stop events. The block then returns one acknowledge decision for each byte. The first byte after a start is checked against a 7-bit slave address. The two low address bits are set by configuration pins. The lowest bit of that byte selects the direction.

On a write, the bytes that follow alternate between control bytes and data bytes. Bit 7 of a control byte selects continuation: one data byte and then another control byte, or an open-ended data stream that lasts until the next start or stop. Bit 6 selects the destination. Data goes either to a command strobe output or to a display RAM write port whose address pointer advances by itself.

On a read, the block offers one byte to the engine straight after the address. That byte is the status input when the destination bit of the last control byte was 0, and the RAM read data otherwise.

Received bytes use valid/ready. The engine holds `rx_valid_i` and `rx_data_i` until `rx_ready_o` is high at a clock edge. The block pulls `rx_ready_o` low only while a command-bound byte waits on `cmd_ready_i` low, or during a start or stop cycle. The command output follows valid/ready in the same way. Outgoing read bytes are offered on `tx_valid_o`/`tx_data_o` and stay steady while `tx_ready_i` is low. RAM writes are never stalled.

Top module: `lcd_cmdword_parser`

## Requirements
- R1: The address byte matches when bits 7:3 equal 0,1,1,1,1 and bits 2:1 equal `addr_sel_i`; bit 0 is R/W (1 = read). A matching byte gets `ack_o`=1. A mismatching byte gets `ack_o`=0, and every byte after it gets `ack_o`=0 with no command or RAM effect until the next start.
- R2: Every accepted byte produces a one-cycle `ack_valid_o` pulse in the cycle after acceptance. `ack_o` is 1 for the address, control and data bytes of an addressed write.
- R3: In a control byte, bit 7 is the continuation bit and bit 6 is the destination bit; bits 5:0 have no effect.
- R4: Continuation bit 1: exactly one data byte follows, and the byte after it is parsed as a control byte.
- R5: Continuation bit 0: every following byte is data until a start or stop.
- R6: With destination bit 0, each data byte appears on `cmd_valid_o`/`cmd_data_o` in the same cycle it is presented. `rx_ready_o` follows `cmd_ready_i` for such bytes.
- R7: With destination bit 1, each data byte raises `ram_we_o` with `ram_wdata_o` at address `ram_addr_o`. The pointer then advances by one, and it wraps from RAM_DEPTH-1 to 0.
- R8: A `ptr_load_i` pulse sets `ram_addr_o` to `ptr_load_val_i` from the next cycle, and it takes priority over an advance.
- R9: After a matching address with R/W=1, `tx_valid_o` is high until the next start or stop. `tx_data_o` is `status_i` if the last control byte's destination bit was 0, and `ram_rdata_i` if it was 1.
- R10: A start makes the next byte an address byte, also within a transaction. A stop returns the parser to idle, where bytes get `ack_o`=0 and have no effect.
- R11: After reset the parser is idle, the pointer is 0, the last destination bit is 0, and `cmd_valid_o`, `ram_we_o`, `tx_valid_o` and `ack_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel_i | input | 2 | Low two slave address bits |
| start_i | input | 1 | Start or repeated-start event (one cycle) |
| stop_i | input | 1 | Stop event (one cycle) |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Received byte accepted at this edge |
| ack_valid_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = not acknowledged |
| tx_valid_o | output | 1 | Read byte offered |
| tx_data_o | output | 8 | Read byte |
| tx_ready_i | input | 1 | Engine takes the read byte |
| status_i | input | 8 | Status byte source |
| cmd_valid_o | output | 1 | Command byte valid |
| cmd_data_o | output | 8 | Command byte |
| cmd_ready_i | input | 1 | Command decoder ready |
| ram_we_o | output | 1 | Display RAM write enable |
| ram_addr_o | output | AW | Display RAM address (data pointer) |
| ram_wdata_o | output | 8 | Display RAM write data |
| ram_rdata_i | input | 8 | Display RAM read data at the pointer |
| ptr_load_i | input | 1 | Load data pointer |
| ptr_load_val_i | input | AW | Value for the pointer load |

## Verification
The bench builds the block with RAM_DEPTH set to 6, so a stream of seven RAM bytes carries the pointer across its wrap back to 0. At the default depth that wrap would take hundreds of writes. `addr_sel_i` is tied to 01, which makes 0x7A and 0x7B the matching address bytes and leaves 0x7C as a near-miss address that differs only in the configured bits. With the narrow pointer, a load to a mid-range value and the following write fit in a few cycles.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_ADDR,
    PS_CTRL,
    PS_ONE,
    PS_STREAM,
    PS_READ,
    PS_SKIP
  } parse_state_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CO_BIT = 7;
  localparam int unsigned DC_BIT = 6;
endpackage

// File: rtl/cwp_addr_match.sv
module cwp_addr_match
  import cwp_pkg::*;
#(
  parameter logic [4:0] FIXED_HI = 5'b01111
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [1:0]        sel_i,
  output logic              hit_o,
  output logic              rd_o
);
  logic [6:0] expect_addr;

  assign expect_addr = {FIXED_HI, sel_i};
  assign hit_o       = (byte_i[7:1] == expect_addr);
  assign rd_o        = byte_i[0];
endmodule

// File: rtl/cwp_ptr.sv
module cwp_ptr #(
  parameter int unsigned DEPTH = 918,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_o <= '0;
    end else if (load_i) begin
      ptr_o <= load_val_i;
    end else if (adv_i) begin
      ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + AW'(1);
    end
  end

  // R7
  ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> (ptr_o != $past(ptr_o)));

  // R8
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ptr_o == $past(load_val_i)));
endmodule

// File: rtl/cwp_parse_fsm.sv
module cwp_parse_fsm
  import cwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              addr_hit_i,
  input  logic              addr_rd_i,
  input  logic              cmd_ready_i,
  output logic              rx_ready_o,
  output logic              cmd_valid_o,
  output logic              ram_we_o,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic              tx_valid_o,
  output logic              last_dc_o
);
  parse_state_t state_q, state_d;
  logic dc_q, dc_d;
  logic last_dc_d;
  logic evt, in_data, accept, ack_d;

  assign evt     = start_i | stop_i;
  assign in_data = (state_q == PS_ONE) || (state_q == PS_STREAM);

  always_comb begin
    rx_ready_o = !evt;
    if (in_data && !dc_q) begin
      rx_ready_o = !evt && cmd_ready_i;
    end
  end

  assign accept      = rx_valid_i && rx_ready_o;
  assign cmd_valid_o = rx_valid_i && !evt && in_data && !dc_q;
  assign ram_we_o    = accept && in_data && dc_q;
  assign tx_valid_o  = (state_q == PS_READ);

  always_comb begin
    state_d   = state_q;
    dc_d      = dc_q;
    last_dc_d = last_dc_o;
    ack_d     = 1'b0;
    if (start_i) begin
      state_d = PS_ADDR;
    end else if (stop_i) begin
      state_d = PS_IDLE;
    end else if (accept) begin
      unique case (state_q)
        PS_ADDR: begin
          ack_d = addr_hit_i;
          if (!addr_hit_i) state_d = PS_SKIP;
          else if (addr_rd_i) state_d = PS_READ;
          else state_d = PS_CTRL;
        end
        PS_CTRL: begin
          ack_d     = 1'b1;
          dc_d      = rx_data_i[DC_BIT];
          last_dc_d = rx_data_i[DC_BIT];
          state_d   = rx_data_i[CO_BIT] ? PS_ONE : PS_STREAM;
        end
        PS_ONE: begin
          ack_d   = 1'b1;
          state_d = PS_CTRL;
        end
        PS_STREAM: ack_d = 1'b1;
        default:   ack_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PS_IDLE;
      dc_q        <= 1'b0;
      last_dc_o   <= 1'b0;
      ack_valid_o <= 1'b0;
      ack_o       <= 1'b0;
    end else begin
      state_q     <= state_d;
      dc_q        <= dc_d;
      last_dc_o   <= last_dc_d;
      ack_valid_o <= accept;
      ack_o       <= ack_d;
    end
  end

  // R2
  ack_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> $past(rx_valid_i && rx_ready_o));

  // R6
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && ram_we_o));

  // R9
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> (!cmd_valid_o && !ram_we_o));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> (!tx_valid_o && !ack_valid_o));
endmodule

// File: rtl/lcd_cmdword_parser.sv
module lcd_cmdword_parser
  import cwp_pkg::*;
#(
  parameter int unsigned RAM_DEPTH = 918,
  localparam int unsigned AW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr_sel_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  output logic          rx_ready_o,
  output logic          ack_valid_o,
  output logic          ack_o,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_ready_i,
  input  logic [7:0]    status_i,
  output logic          cmd_valid_o,
  output logic [7:0]    cmd_data_o,
  input  logic          cmd_ready_i,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [7:0]    ram_wdata_o,
  input  logic [7:0]    ram_rdata_i,
  input  logic          ptr_load_i,
  input  logic [AW-1:0] ptr_load_val_i
);
  logic hit, rd, last_dc;

  cwp_addr_match u_match (
    .byte_i (rx_data_i),
    .sel_i  (addr_sel_i),
    .hit_o  (hit),
    .rd_o   (rd)
  );

  cwp_parse_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .addr_hit_i  (hit),
    .addr_rd_i   (rd),
    .cmd_ready_i (cmd_ready_i),
    .rx_ready_o  (rx_ready_o),
    .cmd_valid_o (cmd_valid_o),
    .ram_we_o    (ram_we_o),
    .ack_valid_o (ack_valid_o),
    .ack_o       (ack_o),
    .tx_valid_o  (tx_valid_o),
    .last_dc_o   (last_dc)
  );

  cwp_ptr #(.DEPTH(RAM_DEPTH)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (ram_we_o),
    .load_i     (ptr_load_i),
    .load_val_i (ptr_load_val_i),
    .ptr_o      (ram_addr_o)
  );

  assign cmd_data_o  = rx_data_i;
  assign ram_wdata_o = rx_data_i;
  assign tx_data_o   = last_dc ? ram_rdata_i : status_i;

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i && !start_i && !stop_i && !ptr_load_i)
      |=> $stable(tx_data_o) || !$stable(status_i) || !$stable(ram_rdata_i));
endmodule

// File: tb/lcd_cmdword_parser_tb.sv
module lcd_cmdword_parser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 6;
  localparam int AW = $clog2(DEPTH);
  localparam int NV = 25;

  // {op[1:0] 0=byte 1=start 2=stop, data[7:0], cmd, we, ack, addr[3:0]}
  localparam logic [16:0] VEC [0:NV-1] = '{
    {2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0},
    {2'd0, 8'h7A, 1'b0, 1'b0, 1'b1, 4'd0},
    {2'd0, 8'h9F, 1'b0, 1'b0, 1'b1, 4'd0},
    {2'd0, 8'h21, 1'b1, 1'b0, 1'b1, 4'd0},
    {2'd0, 8'hC0, 1'b0, 1'b0, 1'b1, 4'd0},
    {2'd0, 8'h11, 1'b0, 1'b1, 1'b1, 4'd0},
    {2'd0, 8'h40, 1'b0, 1'b0, 1'b1, 4'd0},
    {2'd0, 8'h12, 1'b0, 1'b1, 1'b1, 4'd1},
    {2'd0, 8'h13, 1'b0, 1'b1, 1'b1, 4'd2},
    {2'd0, 8'h14, 1'b0, 1'b1, 1'b1, 4'd3},
    {2'd0, 8'h15, 1'b0, 1'b1, 1'b1, 4'd4},
    {2'd0, 8'h16, 1'b0, 1'b1, 1'b1, 4'd5},
    {2'd0, 8'h17, 1'b0, 1'b1, 1'b1, 4'd0},
    {2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0},
    {2'd0, 8'h55, 1'b0, 1'b0, 1'b0, 4'd0},
    {2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0},
    {2'd0, 8'h7C, 1'b0, 1'b0, 1'b0, 4'd0},
    {2'd0, 8'h80, 1'b0, 1'b0, 1'b0, 4'd0},
    {2'd0, 8'h21, 1'b0, 1'b0, 1'b0, 4'd0},
    {2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0},
    {2'd0, 8'h7A, 1'b0, 1'b0, 1'b1, 4'd0},
    {2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 4'd0},
    {2'd0, 8'h33, 1'b1, 1'b0, 1'b1, 4'd0},
    {2'd0, 8'h34, 1'b1, 1'b0, 1'b1, 4'd0},
    {2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic tx_ready_i = 1'b0, cmd_ready_i = 1'b1, ptr_load_i = 1'b0;
  logic [7:0] status_i = 8'hA5, ram_rdata_i = 8'h3C;
  logic [AW-1:0] ptr_load_val_i = '0;
  logic rx_ready_o, ack_valid_o, ack_o, tx_valid_o, cmd_valid_o, ram_we_o;
  logic [7:0] tx_data_o, cmd_data_o, ram_wdata_o;
  logic [AW-1:0] ram_addr_o;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_cmdword_parser #(.RAM_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_sel_i(2'b01),
    .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
    .status_i(status_i),
    .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o), .cmd_ready_i(cmd_ready_i),
    .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
    .ram_rdata_i(ram_rdata_i),
    .ptr_load_i(ptr_load_i), .ptr_load_val_i(ptr_load_val_i)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_evt(input bit is_start);
    @(negedge clk);
    start_i = is_start;
    stop_i  = !is_start;
    @(negedge clk);
    start_i = 1'b0;
    stop_i  = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic e_cmd, input logic e_we,
                      input logic e_ack, input logic [AW-1:0] e_addr, input string req);
    @(negedge clk);
    rx_valid_i = 1'b1;
    rx_data_i  = b;
    #1;
    check({req, " cmd_valid"}, 16'(cmd_valid_o), 16'(e_cmd));
    check({req, " ram_we"}, 16'(ram_we_o), 16'(e_we));
    if (e_cmd) check({req, " cmd_data"}, 16'(cmd_data_o), 16'(b));
    if (e_we) begin
      check({req, " ram_addr"}, 16'(ram_addr_o), 16'(e_addr));
      check({req, " ram_wdata"}, 16'(ram_wdata_o), 16'(b));
    end
    @(negedge clk);
    rx_valid_i = 1'b0;
    check({req, " ack"}, {ack_valid_o, ack_o}, {1'b1, e_ack});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 outputs", {12'd0, cmd_valid_o, ram_we_o, tx_valid_o, ack_valid_o}, 16'd0);
    check("R11 pointer", 16'(ram_addr_o), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R7 R10: vector walk
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      if (v[16:15] == 2'd1) pulse_evt(1'b1);
      else if (v[16:15] == 2'd2) pulse_evt(1'b0);
      else send(v[14:7], v[6], v[5], v[4], AW'(v[3:0]), $sformatf("R1-7/R10 vec%0d", i));
    end

    // R9 read returns status when last destination bit was 0
    pulse_evt(1'b1);
    send(8'h7B, 1'b0, 1'b0, 1'b1, '0, "R9 rd addr");
    check("R9 tx_valid", 16'(tx_valid_o), 16'd1);
    check("R9 status byte", 16'(tx_data_o), 16'hA5);
    pulse_evt(1'b0);
    check("R10 stop ends read", 16'(tx_valid_o), 16'd0);

    // R8 pointer load
    @(negedge clk);
    ptr_load_i = 1'b1;
    ptr_load_val_i = AW'(3);
    @(negedge clk);
    ptr_load_i = 1'b0;
    check("R8 load", 16'(ram_addr_o), 16'd3);
    pulse_evt(1'b1);
    send(8'h7A, 1'b0, 1'b0, 1'b1, '0, "R8 addr");
    send(8'hC0, 1'b0, 1'b0, 1'b1, '0, "R8 ctrl");
    send(8'h99, 1'b0, 1'b1, 1'b1, AW'(3), "R8 write at loaded");
    check("R7 advance", 16'(ram_addr_o), 16'd4);

    // R9 read returns RAM data when last destination bit was 1
    pulse_evt(1'b1);
    send(8'h7B, 1'b0, 1'b0, 1'b1, '0, "R9 rd addr2");
    check("R9 ram byte", 16'(tx_data_o), 16'h3C);
    @(negedge clk);
    tx_ready_i = 1'b1;
    @(negedge clk);
    tx_ready_i = 1'b0;
    check("R9 still offered", 16'(tx_valid_o), 16'd1);

    // R6 back-pressure, then R4 return to control parsing
    pulse_evt(1'b1);
    send(8'h7A, 1'b0, 1'b0, 1'b1, '0, "R6 addr");
    send(8'h80, 1'b0, 1'b0, 1'b1, '0, "R6 ctrl");
    @(negedge clk);
    cmd_ready_i = 1'b0;
    rx_valid_i  = 1'b1;
    rx_data_i   = 8'h44;
    #1;
    check("R6 stall ready", 16'(rx_ready_o), 16'd0);
    check("R6 stall valid", 16'(cmd_valid_o), 16'd1);
    @(negedge clk);
    check("R6 no ack while stalled", 16'(ack_valid_o), 16'd0);
    cmd_ready_i = 1'b1;
    #1;
    check("R6 ready follows", 16'(rx_ready_o), 16'd1);
    @(negedge clk);
    rx_valid_i = 1'b0;
    check("R6 ack after accept", {ack_valid_o, ack_o}, 16'b11);
    send(8'hC0, 1'b0, 1'b0, 1'b1, '0, "R4 next is ctrl");
    send(8'h5A, 1'b0, 1'b1, 1'b1, AW'(4), "R4 data after ctrl");
    pulse_evt(1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule